// File: doc/BRIEF.md
# Four-Channel Compare-Driven Output Waveform Controller

This block turns compare-match and counter-zero events from a timer into four output pin levels. Each channel keeps a one-bit output state. Events set, clear or invert that state. The channel's configuration then maps the state onto the pin through a polarity select, or overrides it with a fixed level from a software force.

All configuration lives in one 16-bit control word, with one 4-bit group per channel. The word can be written whole, one byte at a time, or one bit at a time. Compare-match and counter-zero inputs are single-cycle synchronous pulses. The counters, the compare registers and any output-delay logic sit outside the block.

Top module: `tmr_wave_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the control word clears to 0x0000 and every channel's output state clears to inactive, so all four pins read low afterwards.
- R2: A write with `wr_sel`=0 loads the whole control word from `wr_data`. With `wr_sel`=1, only bits 7:0 load from `wr_data[7:0]`. With `wr_sel`=2, only bits 15:8 load from `wr_data[15:8]`. The bits not selected keep their values.
- R3: A write with `wr_sel`=3 loads control bit `wr_idx` from `wr_data[0]` and leaves the other 15 bits unchanged.
- R4: Channel n (n = 1..4) is configured by control bits 4n-1 down to 4n-4: the top bit is the force enable, the next bit is the active-low select, and the lowest two bits are the mode. The channel listens to `cmp_match[n-1]` and drives `pin_out[n-1]`.
- R5: With force off, the pin equals the output state when the active-low bit is 0, and its inverse when that bit is 1. Inactive is therefore low for an active-high channel and high for an active-low channel.
- R6: With force on, the pin equals the active-low bit, whatever events arrive. The output state keeps following events, and it appears on the pin again once force is cleared.
- R7: Mode 0 inverts the channel state on each of its own compare matches and ignores both counter-zero inputs.
- R8: Mode 1 sets the state active on its own compare match and clears it on `cnt_zero[0]`. It ignores `cnt_zero[1]`.
- R9: Mode 2 sets the state active on its own compare match and clears it on `cnt_zero[1]`. It ignores `cnt_zero[0]`.
- R10: Mode 3 sets the state active on its own compare match and clears it on the next channel's compare match. Channel 4 uses channel 1's match.
- R11: When a set event and a clear event reach a channel in the same cycle, the state becomes active.
- R12: An event sampled at a rising edge, and a control write sampled at a rising edge, are visible on the pins right after that same edge and not before it.
- R13: Changing a channel's mode leaves its current state, and so its pin, unchanged. The new mode applies only to later events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 2 | Write width: 0 word, 1 low byte, 2 high byte, 3 single bit |
| wr_idx | input | 4 | Bit index used for single-bit writes |
| wr_data | input | 16 | Write data; bit 0 carries the value for single-bit writes |
| cmp_match | input | 4 | Per-channel compare-match pulses |
| cnt_zero | input | 2 | Counter-zero pulses of the two counters |
| pin_out | output | 4 | Registered output pin levels |

## Verification
On every cycle, the assertions check the following: the state a channel reaches after its own match and after each mode's clear source; the priority of set over clear; that the pin follows the force level and the polarity mapping; and that byte writes leave the other byte unchanged. Only the bench scenarios can show that the encodings are right. That covers which nibble and bit a write lands in, mode changes that keep the state, a state that evolved under force and reappears on release, and the exact edge at which a pin first moves.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  localparam int unsigned CH_NUM  = 4;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned CTRL_W  = CH_NUM * NIB_W;
  localparam int unsigned IDX_W   = $clog2(CTRL_W);
  localparam int unsigned CZ_NUM  = 2;

  typedef enum logic [1:0] {
    TM_TOGGLE = 2'd0,
    TM_CZ0    = 2'd1,
    TM_CZ1    = 2'd2,
    TM_RING   = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    WR_WORD = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2,
    WR_BIT  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic   force_en;
    logic   act_low;
    tmode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_wave_cfg.sv
module tmr_wave_cfg
  import tmr_wave_pkg::*;
#(
  parameter int unsigned W  = CTRL_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  cfg_q,
  output logic [W-1:0]  cfg_d
);
  localparam int unsigned BYTE_W = 8;

  logic [W-1:0] wmask;
  logic [W-1:0] wval;

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam bit IS_LO = (b / BYTE_W) == 0;
    always_comb begin
      wmask[b] = 1'b0;
      wval[b]  = wr_data[b];
      if (wr_en) begin
        unique case (wsel_e'(wr_sel))
          WR_WORD: wmask[b] = 1'b1;
          WR_LO:   wmask[b] = IS_LO;
          WR_HI:   wmask[b] = !IS_LO;
          WR_BIT: begin
            wmask[b] = (wr_idx == IW'(b));
            wval[b]  = wr_data[0];
          end
        endcase
      end
    end
  end

  assign cfg_d = (cfg_q & ~wmask) | (wval & wmask);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  assert_rst_clear_R1: assert property (@(posedge clk) rst |=> cfg_q == '0);
  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == WR_LO) |=> cfg_q[W-1:BYTE_W] == $past(cfg_q[W-1:BYTE_W]));
  assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == WR_HI) |=> cfg_q[BYTE_W-1:0] == $past(cfg_q[BYTE_W-1:0]));
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_wave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  chan_cfg_t         cfg_i,
  input  chan_cfg_t         cfg_nxt_i,
  input  logic              own_cmp_i,
  input  logic              nbr_cmp_i,
  input  logic [CZ_NUM-1:0] cz_i,
  output logic              pin_o
);
  logic state_q;
  logic state_d;
  logic clr_evt;

  always_comb begin
    unique case (cfg_i.mode)
      TM_CZ0:  clr_evt = cz_i[0];
      TM_CZ1:  clr_evt = cz_i[1];
      TM_RING: clr_evt = nbr_cmp_i;
      default: clr_evt = 1'b0;
    endcase
    if (cfg_i.mode == TM_TOGGLE) state_d = state_q ^ own_cmp_i;
    else if (own_cmp_i)          state_d = 1'b1;
    else if (clr_evt)            state_d = 1'b0;
    else                         state_d = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
      pin_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      pin_o   <= cfg_nxt_i.force_en ? cfg_nxt_i.act_low : (state_d ^ cfg_nxt_i.act_low);
    end
  end

  assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == TM_TOGGLE && own_cmp_i) |=> state_q != $past(state_q));
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode != TM_TOGGLE && own_cmp_i) |=> state_q);
  assert_cz0_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == TM_CZ0 && cz_i[0] && !own_cmp_i) |=> !state_q);
  assert_cz1_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == TM_CZ1 && cz_i[1] && !own_cmp_i) |=> !state_q);
  assert_ring_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == TM_RING && nbr_cmp_i && !own_cmp_i) |=> !state_q);
  assert_force_level_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_i.force_en |-> pin_o == cfg_i.act_low);
  assert_polarity_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.force_en |-> pin_o == (state_q ^ cfg_i.act_low));
endmodule

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_wave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [CH_NUM-1:0] cmp_match,
  input  logic [CZ_NUM-1:0] cnt_zero,
  output logic [CH_NUM-1:0] pin_out
);
  logic [CTRL_W-1:0] cfg_q;
  logic [CTRL_W-1:0] cfg_d;

  tmr_wave_cfg #(.W(CTRL_W), .IW(IDX_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .cfg_d   (cfg_d)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    localparam int unsigned NBR = (c + 1) % CH_NUM;
    chan_cfg_t cur_cfg;
    chan_cfg_t nxt_cfg;
    assign cur_cfg = chan_cfg_t'(cfg_q[c*NIB_W +: NIB_W]);
    assign nxt_cfg = chan_cfg_t'(cfg_d[c*NIB_W +: NIB_W]);

    tmr_wave_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_i     (cur_cfg),
      .cfg_nxt_i (nxt_cfg),
      .own_cmp_i (cmp_match[c]),
      .nbr_cmp_i (cmp_match[NBR]),
      .cz_i      (cnt_zero),
      .pin_o     (pin_out[c])
    );
  end
endmodule

// File: tb/tmr_wave_ctrl_tb.sv
module tmr_wave_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  cmp_match = '0;
  logic [1:0]  cnt_zero = '0;
  logic [3:0]  pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_wave_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .cmp_match(cmp_match), .cnt_zero(cnt_zero), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if (pin_out !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_out=%b expected=%b", req, pin_out, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ev(input logic [3:0] cm, input logic [1:0] cz);
    @(negedge clk);
    cmp_match = cm; cnt_zero = cz;
    @(negedge clk);
    cmp_match = '0; cnt_zero = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pins low after reset", 4'b0000);
  endtask

  task automatic t_writes();
    do_reset();
    wr(2'd0, 4'd0, 16'hC8C8);   chk("R2 word write", 4'b1010);
    wr(2'd1, 4'd0, 16'h33CC);   chk("R2 low byte write", 4'b1011);
    wr(2'd2, 4'd0, 16'h8C11);   chk("R2 high byte write keeps low", 4'b0111);
    wr(2'd3, 4'd2, 16'h0000);   chk("R3 bit write clear bit2", 4'b0110);
    wr(2'd3, 4'd10, 16'hFFFE);  chk("R3 bit write clear bit10", 4'b0010);
    wr(2'd3, 4'd14, 16'h0001);  chk("R3 bit write set bit14", 4'b1010);
    do_reset();
    wr(2'd0, 4'd0, 16'h0C00);   chk("R4 channel 3 nibble", 4'b0100);
  endtask

  task automatic t_toggle();
    do_reset();
    ev(4'b0001, 2'b00); chk("R7 toggle on", 4'b0001);
    ev(4'b0000, 2'b11); chk("R7 counter zero ignored", 4'b0001);
    ev(4'b0001, 2'b00); chk("R7 toggle off", 4'b0000);
    ev(4'b1010, 2'b00); chk("R4 independent channels", 4'b1010);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    cmp_match = 4'b0100;
    #2 chk("R12 no change before edge", 4'b0000);
    @(posedge clk);
    #1 chk("R12 change right after edge", 4'b0100);
    @(negedge clk) cmp_match = '0;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0004;
    @(posedge clk);
    #1 chk("R12 write visible after edge", 4'b0101);
    @(negedge clk) wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_cz0();
    do_reset();
    wr(2'd0, 4'd0, 16'h0001);
    ev(4'b0001, 2'b00); chk("R8 set on own match", 4'b0001);
    ev(4'b0000, 2'b10); chk("R8 other counter ignored", 4'b0001);
    ev(4'b0000, 2'b01); chk("R8 clear on counter 0", 4'b0000);
    ev(4'b0001, 2'b01); chk("R11 set beats clear", 4'b0001);
  endtask

  task automatic t_cz1();
    do_reset();
    wr(2'd0, 4'd0, 16'h0002);
    ev(4'b0001, 2'b00); chk("R9 set on own match", 4'b0001);
    ev(4'b0000, 2'b01); chk("R9 other counter ignored", 4'b0001);
    ev(4'b0000, 2'b10); chk("R9 clear on counter 1", 4'b0000);
  endtask

  task automatic t_ring();
    do_reset();
    wr(2'd0, 4'd0, 16'h3333);
    ev(4'b0001, 2'b00); chk("R10 set ch1", 4'b0001);
    ev(4'b0010, 2'b00); chk("R10 ch2 clears ch1", 4'b0010);
    ev(4'b1000, 2'b00); chk("R10 ch4 set", 4'b1010);
    ev(4'b0001, 2'b00); chk("R10 ch1 wraps to clear ch4", 4'b0011);
  endtask

  task automatic t_polarity_force();
    do_reset();
    wr(2'd0, 4'd0, 16'h0004); chk("R5 active low idles high", 4'b0001);
    ev(4'b0001, 2'b00);       chk("R5 active low drives low", 4'b0000);
    do_reset();
    wr(2'd0, 4'd0, 16'h0008);
    ev(4'b0001, 2'b00);       chk("R6 forced low", 4'b0000);
    wr(2'd0, 4'd0, 16'h000C); chk("R6 forced high", 4'b0001);
    ev(4'b0001, 2'b00);       chk("R6 forced high holds", 4'b0001);
    ev(4'b0001, 2'b00);
    wr(2'd0, 4'd0, 16'h0000); chk("R6 state tracked under force", 4'b0001);
  endtask

  task automatic t_mode_change();
    do_reset();
    ev(4'b0001, 2'b00);
    wr(2'd0, 4'd0, 16'h0001); chk("R13 mode change keeps state", 4'b0001);
    wr(2'd0, 4'd0, 16'h0003); chk("R13 second mode change keeps state", 4'b0001);
    ev(4'b0010, 2'b00);       chk("R13 new mode governs", 4'b0010);
  endtask

  initial begin
    t_reset();
    t_writes();
    t_toggle();
    t_timing();
    t_cz0();
    t_cz1();
    t_ring();
    t_polarity_force();
    t_mode_change();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule